// File: doc/BRIEF.md
# Timer Capture, Compare and PWM Channel

This block is one channel of a timer. A separate timebase supplies a shared counter value, the direction it is counting in, and a one-cycle strobe that marks the end of each period. The channel does not count. It watches that counter and, depending on its mode, does one of four things. It can latch the counter when an edge arrives on its input pin. It can drive its output pin when the counter matches a programmed value. It can produce an edge-aligned PWM waveform. It can produce a center-aligned PWM waveform.

Software programs the channel through three strobed writes: a configuration write carrying a mode field and a select field, a value write carrying the channel value, and a write-one-to-clear strobe for the event flag. A timer-wide input forces the channel into center-aligned PWM whatever its own mode field holds. In both PWM modes, the value written is kept in a holding register. It becomes the active duty only at the end of a period, so the waveform never sees a partly written update.

Top module: `tmr_chan`

## Requirements
- R1: After reset, `pin_o`, `flag_o` and `cap_o` are all zero.
- R2: Mode 00 is capture. The input passes through two synchronizing flops. Select 01 captures on rising edges, 10 on falling edges, 11 on both edges, and 00 on none. `cap_o` takes the value of `cnt_i` at the third rising clock edge after the pin changes, and keeps its value when no capture occurs.
- R3: Mode 01 is compare. On a clock edge where `cnt_i` equals the channel value, the select field acts on the pin: 11 sets it, 10 clears it, 01 toggles it, and 00 leaves it unchanged. A value write takes effect at once in this mode.
- R4: Mode 10 is edge-aligned PWM. The timebase counts 0..M and strobes `tc_i` at M. The output is asserted on the edge where the count is 0 and deasserted on the edge where the count equals the duty, and deassertion wins when both happen on the same edge. Over one period the output is true for min(duty, M+1) cycles.
- R5: In both PWM modes, select bit 0 picks the polarity: 0 gives high-true pulses and 1 gives low-true pulses.
- R6: In both PWM modes, a value write loads only the holding register. The active duty changes only on an edge where `tc_i` is high.
- R7: Mode 11 is center-aligned PWM. The timebase counts up 0..M-1, then down M..1, and strobes `tc_i` at the bottom. On the `tc_i` edge the output is asserted unless the new duty is 0. A match while counting up deasserts it, and a match while counting down asserts it. Over one period of 2M cycles the output is true for 2*duty cycles, capped at 2M.
- R8: When `center_force_i` is high, the channel behaves in center-aligned PWM whatever its mode field holds.
- R9: A capture in mode 00, or a match in any other mode, sets `flag_o` on the following cycle. A `flag_clr_i` pulse clears the flag, but an event in the same cycle keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | W | Shared counter value |
| cnt_down_i | input | 1 | Counter is counting down |
| tc_i | input | 1 | End-of-period strobe |
| center_force_i | input | 1 | Timer-wide force to center-aligned PWM |
| pin_i | input | 1 | Asynchronous capture input |
| pin_o | output | 1 | Channel output pin |
| wr_cfg_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 2 | Mode field |
| cfg_sel_i | input | 2 | Edge, action or polarity select |
| wr_val_i | input | 1 | Channel value write strobe |
| val_i | input | W | Channel value |
| cap_o | output | W | Last captured counter value |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the flag |
| flag_o | output | 1 | Channel event flag and interrupt |

## Verification
The assertions check the following on every cycle:
- a held capture value and the exact counter value stored on a capture;
- the set and clear compare actions;
- the deassertion level of the edge-aligned output on a match, polarity included;
- that the active duty stays frozen between period ends in PWM;
- that the flag is set by an event and survives a simultaneous clear.

Only the bench scenarios can show these:
- the high-time count of whole PWM periods against the duty;
- the three-edge capture latency for each edge select;
- toggle and no-action compare;
- the effect of the center-aligned force.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
  typedef enum logic [1:0] {
    MD_CAPT = 2'b00,
    MD_CMP  = 2'b01,
    MD_EPWM = 2'b10,
    MD_CPWM = 2'b11
  } mode_e;
endpackage

// File: rtl/tmr_chan_sync.sv
module tmr_chan_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_i,
  input  logic       en_i,
  input  logic [1:0] sel_i,
  output logic       evt_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] sh_q;
  logic          rise, fall;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[LAST-1:0], pin_i};
  end

  assign rise  = sh_q[LAST-1] & ~sh_q[LAST];
  assign fall  = ~sh_q[LAST-1] & sh_q[LAST];
  assign evt_o = en_i & ((sel_i[0] & rise) | (sel_i[1] & fall));
endmodule

// File: rtl/tmr_chan_wave.sv
module tmr_chan_wave
  import tmr_chan_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  mode_e        mode_i,
  input  logic [1:0]   sel_i,
  input  logic [W-1:0] cnt_i,
  input  logic         down_i,
  input  logic         tc_i,
  input  logic [W-1:0] act_i,
  input  logic         nxt_nz_i,
  output logic         match_o,
  output logic         pin_o
);
  logic raw_q, raw_n, pin_q, pwm;

  assign match_o = (cnt_i == act_i);
  assign pwm     = (mode_i == MD_EPWM) || (mode_i == MD_CPWM);

  always_comb begin
    raw_n = raw_q;
    case (mode_i)
      MD_CMP: begin
        if (match_o) begin
          case (sel_i)
            2'b01:   raw_n = ~raw_q;
            2'b10:   raw_n = 1'b0;
            2'b11:   raw_n = 1'b1;
            default: raw_n = raw_q;
          endcase
        end
      end
      MD_EPWM: begin
        if (match_o)                raw_n = 1'b0;
        else if (cnt_i == '0)       raw_n = 1'b1;
      end
      MD_CPWM: begin
        if (tc_i)                   raw_n = nxt_nz_i;
        else if (match_o)           raw_n = down_i;
      end
      default: raw_n = raw_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= 1'b0;
      pin_q <= 1'b0;
    end else begin
      raw_q <= raw_n;
      pin_q <= raw_n ^ (pwm & sel_i[0]);
    end
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/tmr_chan_flag.sv
module tmr_chan_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter int W         = 16,
  parameter int SYNC_FLOPS = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt_i,
  input  logic         cnt_down_i,
  input  logic         tc_i,
  input  logic         center_force_i,
  input  logic         pin_i,
  output logic         pin_o,
  input  logic         wr_cfg_i,
  input  logic [1:0]   cfg_mode_i,
  input  logic [1:0]   cfg_sel_i,
  input  logic         wr_val_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] cap_o,
  input  logic         flag_clr_i,
  output logic         flag_o
);
  mode_e        mode_q, eff_mode;
  logic [1:0]   sel_q;
  logic [W-1:0] buf_q, act_q, cap_q;
  logic         cap_evt, match, chan_evt, is_pwm, is_capt;

  assign eff_mode = center_force_i ? MD_CPWM : mode_q;
  assign is_pwm   = (eff_mode == MD_EPWM) || (eff_mode == MD_CPWM);
  assign is_capt  = (eff_mode == MD_CAPT);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_CAPT;
      sel_q  <= 2'b00;
    end else if (wr_cfg_i) begin
      mode_q <= mode_e'(cfg_mode_i);
      sel_q  <= cfg_sel_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_val_i) buf_q <= val_i;
      if (is_pwm) begin
        if (tc_i) act_q <= buf_q;
      end else if (wr_val_i) begin
        act_q <= val_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          cap_q <= '0;
    else if (cap_evt) cap_q <= cnt_i;
  end

  tmr_chan_sync #(.STAGES(SYNC_FLOPS)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin_i (pin_i),
    .en_i  (is_capt),
    .sel_i (sel_q),
    .evt_o (cap_evt)
  );

  tmr_chan_wave #(.W(W)) u_wave (
    .clk      (clk),
    .rst      (rst),
    .mode_i   (eff_mode),
    .sel_i    (sel_q),
    .cnt_i    (cnt_i),
    .down_i   (cnt_down_i),
    .tc_i     (tc_i),
    .act_i    (act_q),
    .nxt_nz_i (buf_q != '0),
    .match_o  (match),
    .pin_o    (pin_o)
  );

  assign chan_evt = is_capt ? cap_evt : match;

  tmr_chan_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .set_i  (chan_evt),
    .clr_i  (flag_clr_i),
    .flag_o (flag_o)
  );

  assign cap_o = cap_q;
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
  import tmr_chan_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input mode_e        eff_mode,
  input logic [1:0]   sel_q,
  input logic [W-1:0] cnt_i,
  input logic [W-1:0] act_q,
  input logic         tc_i,
  input logic         cap_evt,
  input logic [W-1:0] cap_o,
  input logic         pin_o,
  input logic         chan_evt,
  input logic         flag_clr_i,
  input logic         flag_o
);
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cap_evt |=> $stable(cap_o)); // R2
  AST_CAP_VALUE: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> cap_o == $past(cnt_i)); // R2
  AST_CMP_SET: assert property (@(posedge clk) disable iff (rst)
    (eff_mode == MD_CMP && sel_q == 2'b11 && cnt_i == act_q) |=> pin_o); // R3
  AST_CMP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (eff_mode == MD_CMP && sel_q == 2'b10 && cnt_i == act_q) |=> !pin_o); // R3
  AST_EPWM_MATCH_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (eff_mode == MD_EPWM && cnt_i == act_q) |=> pin_o == $past(sel_q[0])); // R5
  AST_DUTY_FROZEN: assert property (@(posedge clk) disable iff (rst)
    ((eff_mode == MD_EPWM || eff_mode == MD_CPWM) && !tc_i) |=> $stable(act_q)); // R6
  AST_FLAG_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
    chan_evt |=> flag_o); // R9
  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (flag_clr_i && !chan_evt) |=> !flag_o); // R9
endmodule

bind tmr_chan tmr_chan_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .eff_mode   (eff_mode),
  .sel_q      (sel_q),
  .cnt_i      (cnt_i),
  .act_q      (act_q),
  .tc_i       (tc_i),
  .cap_evt    (cap_evt),
  .cap_o      (cap_o),
  .pin_o      (pin_o),
  .chan_evt   (chan_evt),
  .flag_clr_i (flag_clr_i),
  .flag_o     (flag_o)
);

// File: tb/test_tmr_chan.sv
module test_tmr_chan;
  localparam int W = 16;
  localparam int M = 5;
  localparam logic [W-1:0] IDLE = 16'hFFF0;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] cnt_i = IDLE;
  logic         cnt_down_i = 1'b0;
  logic         tc_i = 1'b0;
  logic         center_force_i = 1'b0;
  logic         pin_i = 1'b0;
  logic         pin_o;
  logic         wr_cfg_i = 1'b0;
  logic [1:0]   cfg_mode_i = 2'b00;
  logic [1:0]   cfg_sel_i = 2'b00;
  logic         wr_val_i = 1'b0;
  logic [W-1:0] val_i = '0;
  logic [W-1:0] cap_o;
  logic         flag_clr_i = 1'b0;
  logic         flag_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr_chan #(.W(W)) i_tmr_chan (
    .clk(clk), .rst(rst), .cnt_i(cnt_i), .cnt_down_i(cnt_down_i), .tc_i(tc_i),
    .center_force_i(center_force_i), .pin_i(pin_i), .pin_o(pin_o),
    .wr_cfg_i(wr_cfg_i), .cfg_mode_i(cfg_mode_i), .cfg_sel_i(cfg_sel_i),
    .wr_val_i(wr_val_i), .val_i(val_i), .cap_o(cap_o),
    .flag_clr_i(flag_clr_i), .flag_o(flag_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [W-1:0] c, input logic dn, input logic tc);
    cnt_i = c; cnt_down_i = dn; tc_i = tc;
    @(negedge clk);
    cnt_i = IDLE; tc_i = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] md, input logic [1:0] sl);
    wr_cfg_i = 1'b1; cfg_mode_i = md; cfg_sel_i = sl;
    step(IDLE, 1'b0, 1'b0);
    wr_cfg_i = 1'b0;
  endtask

  task automatic wval(input logic [W-1:0] v);
    wr_val_i = 1'b1; val_i = v;
    step(IDLE, 1'b0, 1'b0);
    wr_val_i = 1'b0;
  endtask

  task automatic clr_flag();
    flag_clr_i = 1'b1;
    step(IDLE, 1'b0, 1'b0);
    flag_clr_i = 1'b0;
  endtask

  // one edge-aligned period, returns cycles with pin_o high
  task automatic edge_period(output int highs);
    highs = 0;
    for (int c = 0; c <= M; c++) begin
      step(W'(c), 1'b0, c == M);
      if (pin_o) highs++;
    end
  endtask

  // one center-aligned period of 2M cycles
  task automatic center_period(output int highs);
    highs = 0;
    for (int i = 0; i < 2 * M; i++) begin
      if (i < M) step(W'(i), 1'b0, i == 0);
      else       step(W'(2 * M - i), 1'b1, 1'b0);
      if (pin_o) highs++;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int h;
    int e;
    logic [W-1:0] prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(pin_o, 0, "R1 pin");
    chk(flag_o, 0, "R1 flag");
    chk(cap_o, 0, "R1 cap");

    // R2 capture, every edge select and both edge directions
    prev = '0;
    for (int s = 0; s < 4; s++) begin
      cfg(2'b00, 2'(s));
      clr_flag();
      pin_i = 1'b1;
      for (int k = 0; k < 4; k++) step(W'(16'h0100 + s), 1'b0, 1'b0);
      if (s[0]) prev = W'(16'h0100 + s);
      chk(cap_o, prev, "R2 rising");
      chk(flag_o, s[0], "R9 capture flag rising");
      clr_flag();
      pin_i = 1'b0;
      for (int k = 0; k < 4; k++) step(W'(16'h0200 + s), 1'b0, 1'b0);
      if (s[1]) prev = W'(16'h0200 + s);
      chk(cap_o, prev, "R2 falling");
      chk(flag_o, s[1], "R9 capture flag falling");
    end
    // R2 latency: value is taken on the third edge
    cfg(2'b00, 2'b01);
    pin_i = 1'b1;
    step(16'h0301, 1'b0, 1'b0);
    step(16'h0302, 1'b0, 1'b0);
    chk(cap_o, prev, "R2 not yet");
    step(16'h0303, 1'b0, 1'b0);
    chk(cap_o, 16'h0303, "R2 third edge");
    pin_i = 1'b0;
    repeat (3) step(IDLE, 1'b0, 1'b0);

    // R3 compare actions
    cfg(2'b01, 2'b11);
    wval(16'h0042);
    clr_flag();
    step(16'h0042, 1'b0, 1'b0);
    chk(pin_o, 1, "R3 set");
    chk(flag_o, 1, "R9 compare flag");
    cfg(2'b01, 2'b00);
    clr_flag();
    step(16'h0042, 1'b0, 1'b0);
    chk(pin_o, 1, "R3 no action");
    chk(flag_o, 1, "R9 flag without action");
    cfg(2'b01, 2'b10);
    step(16'h0042, 1'b0, 1'b0);
    chk(pin_o, 0, "R3 clear");
    cfg(2'b01, 2'b01);
    step(16'h0042, 1'b0, 1'b0);
    chk(pin_o, 1, "R3 toggle up");
    step(16'h0043, 1'b0, 1'b0);
    chk(pin_o, 1, "R3 no match");
    step(16'h0042, 1'b0, 1'b0);
    chk(pin_o, 0, "R3 toggle down");
    // R9 event wins over clear
    flag_clr_i = 1'b1;
    step(16'h0042, 1'b0, 1'b0);
    flag_clr_i = 1'b0;
    chk(flag_o, 1, "R9 event beats clear");
    clr_flag();
    chk(flag_o, 0, "R9 clear");

    // R4/R5 edge-aligned sweep
    for (int p = 0; p < 2; p++) begin
      for (int d = 0; d <= M + 2; d++) begin
        cfg(2'b10, 2'(p));
        wval(W'(d));
        edge_period(h);
        edge_period(h);
        e = (d < M + 1) ? d : M + 1;
        if (p == 1) e = M + 1 - e;
        chk(h, e, p == 1 ? "R5 edge low-true" : "R4 edge high count");
      end
    end

    // R6 buffering: mid-period write waits for period end
    cfg(2'b10, 2'b00);
    wval(W'(2));
    edge_period(h);
    step(16'h0000, 1'b0, 1'b0);
    wval(W'(4));
    h = pin_o ? 1 : 0;
    for (int c = 1; c <= M; c++) begin
      step(W'(c), 1'b0, c == M);
      if (pin_o) h++;
    end
    chk(h, 2, "R6 old duty kept");
    edge_period(h);
    chk(h, 4, "R6 new duty after period end");

    // R7/R5 center-aligned sweep
    for (int p = 0; p < 2; p++) begin
      for (int d = 0; d <= M + 1; d++) begin
        cfg(2'b11, 2'(p));
        wval(W'(d));
        center_period(h);
        center_period(h);
        e = (d >= M) ? 2 * M : 2 * d;
        if (p == 1) e = 2 * M - e;
        chk(h, e, p == 1 ? "R5 center low-true" : "R7 center high count");
      end
    end

    // R8 force to center while mode field says compare
    cfg(2'b01, 2'b00);
    center_force_i = 1'b1;
    wval(W'(3));
    center_period(h);
    center_period(h);
    chk(h, 6, "R8 forced center");
    center_force_i = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule